// File: doc/BRIEF.md
# Serial ADC Power-Mode Controller

This block is the digital front of a serial-output converter whose power state is set only by the host's framing. The host lowers an active-low select line to open a frame and clocks it with a serial clock. The block counts falling edges of that clock inside each frame. When the select line rises again, the edge count decides what happens: the block stays powered, drops into a low-power state, or finishes waking. No real conversion takes place. Each frame shifts out a placeholder word, most significant bit first. The word is a run of zero bits followed by a running frame code.

Both host lines are sampled on the block's own clock, `clk`, so every level the host drives must last at least two `clk` cycles. Each line crosses one capture stage and one edge stage. An edge therefore acts on state and outputs two `clk` edges after the host drives it. The serial data output has no valid/ready handshake and cannot apply back-pressure: the host's clock paces every bit. The `data_valid` pin tells the host whether the word in the current frame can be used. `sdata_oe` marks when `sdata` would be driven rather than left at high impedance.

Top module: `adc_pm_ctrl`

## Requirements
- R1: After reset the block is powered (`powered`=1), `sdata_oe`=0, `data_valid`=0 and `sdata`=0.
- R2: A select fall while powered opens a valid frame (`sdata_oe`=1, `data_valid`=1) and loads a 16-bit word. The word's top 4 bits are 0 and its low 12 bits are the number of earlier frames that opened while powered, modulo 4096. `sdata` presents bit 15 first and moves down one bit after each serial-clock fall. Once all 16 bits are out, `sdata` reads 0.
- R3: While powered, a select rise after fewer than 2 serial-clock falls leaves the block powered.
- R4: While powered, a select rise after 2 to 9 serial-clock falls aborts the frame. `powered` and `sdata_oe` both go to 0 at the same clock edge.
- R5: While powered, a select rise after 10 or more serial-clock falls ends the frame and leaves the block powered.
- R6: A select fall while powered down opens a wake frame. In a wake frame `sdata_oe`=1 and `data_valid`=0.
- R7: In a wake frame, a select rise after fewer than 10 falls returns the block to power-down (`powered` stays 0), so a burst of 8 clocks does not wake it.
- R8: A wake frame sets `powered` to 1 at its 16th fall, or when select rises after 10 or more falls. The next frame that opens is valid.
- R9: The edge count resets at each select fall and stops at 16. Further falls in the same frame change no output.
- R10: Whenever no frame is open, `sdata_oe`=0, `sdata`=0 and `data_valid`=0. Serial-clock falls while select is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; both host lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, idle high |
| sdata | output | 1 | Serial data bit, forced to 0 when not enabled |
| sdata_oe | output | 1 | Output enable for the serial data line |
| powered | output | 1 | High when the block is fully powered |
| data_valid | output | 1 | High while the open frame carries a usable word |

## Verification
The bench places select rises on every side of the window edges at 2 and 10, with the block both powered and powered down. A design off by one at either edge would sleep on a one-clock glitch, would fail to sleep on a 2-edge abort, or would wake on an 8-clock burst. The wake path is driven to completion both by a full 16-edge frame and by an early rise after 12 edges. This catches a design that wakes too late, or one that marks the wake frame's word as valid. Frames with 20 clock edges check that extra edges neither shift out stray bits nor move the count past its limit. The frame code is followed across aborted and wake frames, so a code that advances on the wrong frames shows up as wrong data bits.

// File: rtl/adc_pm_pkg.sv
package adc_pm_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_ASLEEP = 2'd1,
    PM_WAKING = 2'd2
  } pm_state_e;

  typedef struct packed {
    logic sel_fall;
    logic sel_rise;
    logic clk_fall;
  } line_evt_t;

endpackage

// File: rtl/adc_pm_edges.sv
module adc_pm_edges
  import adc_pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n,
  input  logic      sclk,
  output line_evt_t evt
);

  logic cs_cur, cs_prev;
  logic sc_cur, sc_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_cur  <= 1'b1;
      cs_prev <= 1'b1;
      sc_cur  <= 1'b1;
      sc_prev <= 1'b1;
    end else begin
      cs_cur  <= cs_n;
      cs_prev <= cs_cur;
      sc_cur  <= sclk;
      sc_prev <= sc_cur;
    end
  end

  always_comb begin
    evt.sel_fall = cs_prev & ~cs_cur;
    evt.sel_rise = ~cs_prev & cs_cur;
    evt.clk_fall = sc_prev & ~sc_cur;
  end

endmodule

// File: rtl/adc_pm_counter.sv
module adc_pm_counter #(
  parameter int FRAME_LEN = 16,
  localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fall,
  input  logic             sel_rise,
  input  logic             clk_fall,
  output logic [CNT_W-1:0] cnt,
  output logic             clk_step,
  output logic             last_step
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(FRAME_LEN - 1);

  logic open_q;

  assign clk_step  = clk_fall & open_q & ~sel_fall & ~sel_rise & (cnt != FULL_C);
  assign last_step = clk_step & (cnt == PRE_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      open_q <= 1'b0;
    end else if (sel_fall) begin
      cnt    <= '0;
      open_q <= 1'b1;
    end else if (sel_rise) begin
      open_q <= 1'b0;
    end else if (clk_step) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_pm_power_fsm.sv
module adc_pm_power_fsm
  import adc_pm_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int ABORT_LO  = 2,
  parameter int ABORT_HI  = 10,
  localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fall,
  input  logic             sel_rise,
  input  logic             last_step,
  input  logic [CNT_W-1:0] cnt,
  output pm_state_e        state,
  output logic             frame_valid
);

  localparam logic [CNT_W-1:0] LO_C = CNT_W'(ABORT_LO);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(ABORT_HI);

  logic in_abort_win;
  logic past_wake_mark;

  assign in_abort_win   = (cnt >= LO_C) && (cnt < HI_C);
  assign past_wake_mark = (cnt >= HI_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PM_ACTIVE;
    end else begin
      unique case (state)
        PM_ACTIVE: if (sel_rise && in_abort_win) state <= PM_ASLEEP;
        PM_ASLEEP: if (sel_fall) state <= PM_WAKING;
        PM_WAKING: begin
          if (sel_rise)       state <= past_wake_mark ? PM_ACTIVE : PM_ASLEEP;
          else if (last_step) state <= PM_ACTIVE;
        end
        default: state <= PM_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        frame_valid <= 1'b0;
    else if (sel_fall) frame_valid <= (state == PM_ACTIVE);
    else if (sel_rise) frame_valid <= 1'b0;
  end

endmodule

// File: rtl/adc_pm_shifter.sv
module adc_pm_shifter #(
  parameter int FRAME_LEN  = 16,
  parameter int LEAD_ZEROS = 4,
  localparam int CODE_W = FRAME_LEN - LEAD_ZEROS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_fall,
  input  logic sel_rise,
  input  logic clk_step,
  input  logic load_ok,
  output logic sdata,
  output logic sdata_oe
);

  logic [CODE_W-1:0]    code_q;
  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] load_word;

  generate
    if (LEAD_ZEROS > 0) begin : g_pad
      assign load_word = {{LEAD_ZEROS{1'b0}}, code_q};
    end else begin : g_nopad
      assign load_word = code_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= '0;
      shreg    <= '0;
      sdata_oe <= 1'b0;
    end else if (sel_fall) begin
      shreg    <= load_word;
      sdata_oe <= 1'b1;
      if (load_ok) code_q <= code_q + 1'b1;
    end else if (sel_rise) begin
      sdata_oe <= 1'b0;
    end else if (clk_step) begin
      shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
    end
  end

  assign sdata = sdata_oe & shreg[FRAME_LEN-1];

endmodule

// File: rtl/adc_pm_ctrl.sv
module adc_pm_ctrl
  import adc_pm_pkg::*;
#(
  parameter int FRAME_LEN  = 16,
  parameter int LEAD_ZEROS = 4,
  parameter int ABORT_LO   = 2,
  parameter int ABORT_HI   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic sdata,
  output logic sdata_oe,
  output logic powered,
  output logic data_valid
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  line_evt_t        evt;
  logic [CNT_W-1:0] edge_cnt;
  logic             clk_step;
  logic             last_step;
  pm_state_e        state;

  adc_pm_edges u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .evt   (evt)
  );

  adc_pm_counter #(.FRAME_LEN(FRAME_LEN)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_fall  (evt.sel_fall),
    .sel_rise  (evt.sel_rise),
    .clk_fall  (evt.clk_fall),
    .cnt       (edge_cnt),
    .clk_step  (clk_step),
    .last_step (last_step)
  );

  adc_pm_power_fsm #(
    .FRAME_LEN (FRAME_LEN),
    .ABORT_LO  (ABORT_LO),
    .ABORT_HI  (ABORT_HI)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_fall    (evt.sel_fall),
    .sel_rise    (evt.sel_rise),
    .last_step   (last_step),
    .cnt         (edge_cnt),
    .state       (state),
    .frame_valid (data_valid)
  );

  adc_pm_shifter #(
    .FRAME_LEN  (FRAME_LEN),
    .LEAD_ZEROS (LEAD_ZEROS)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_fall (evt.sel_fall),
    .sel_rise (evt.sel_rise),
    .clk_step (clk_step),
    .load_ok  (state == PM_ACTIVE),
    .sdata    (sdata),
    .sdata_oe (sdata_oe)
  );

  assign powered = (state == PM_ACTIVE);

endmodule

// File: rtl/adc_pm_ctrl_chk.sv
module adc_pm_ctrl_chk #(
  parameter int FRAME_LEN  = 16,
  parameter int LEAD_ZEROS = 4,
  localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdata,
  input logic             sdata_oe,
  input logic             powered,
  input logic             data_valid,
  input logic [CNT_W-1:0] frame_cnt
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FRAME_LEN);

  assert_first_bit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> powered && sdata_oe && (LEAD_ZEROS == 0 || !sdata));

  assert_abort_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(powered) |-> !sdata_oe && $past(sdata_oe));

  assert_wake_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && !powered) |-> !data_valid);

  assert_wake_frame_unusable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powered) |-> !data_valid);

  assert_count_capped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= FULL_C);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata && !data_valid);

endmodule

bind adc_pm_ctrl adc_pm_ctrl_chk #(
  .FRAME_LEN  (FRAME_LEN),
  .LEAD_ZEROS (LEAD_ZEROS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sdata      (sdata),
  .sdata_oe   (sdata_oe),
  .powered    (powered),
  .data_valid (data_valid),
  .frame_cnt  (edge_cnt)
);

// File: tb/test_adc_pm_ctrl.sv
module test_adc_pm_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic sdata, sdata_oe, powered, data_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_pm_ctrl i_adc_pm_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sdata(sdata), .sdata_oe(sdata_oe), .powered(powered), .data_valid(data_valid)
  );

  // reference model: state 0 powered, 1 asleep, 2 waking
  logic [1:0] hist[$];
  int m_state, m_cnt, m_code, m_word;
  bit m_open, m_oe, m_valid;

  task automatic model_step(logic [1:0] a, logic [1:0] b);
    bit cf, cr, kf;
    cf = a[1] && !b[1];
    cr = !a[1] && b[1];
    kf = a[0] && !b[0];
    if (cf) begin
      m_cnt = 0; m_open = 1; m_oe = 1;
      m_word = m_code;
      m_valid = (m_state == 0);
      if (m_state == 0) m_code = (m_code + 1) % 4096;
      if (m_state == 1) m_state = 2;
    end else if (cr) begin
      m_open = 0; m_oe = 0; m_valid = 0;
      if (m_state == 0 && m_cnt >= 2 && m_cnt < 10) m_state = 1;
      else if (m_state == 2) m_state = (m_cnt >= 10) ? 0 : 1;
    end else if (kf && m_open && m_cnt < 16) begin
      m_cnt++;
      if (m_state == 2 && m_cnt == 16) m_state = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_code = 0; m_word = 0;
      m_open = 0; m_oe = 0; m_valid = 0;
      hist.delete();
      hist.push_back(2'b11);
    end else begin
      if (hist.size() >= 2) begin
        model_step(hist[0], hist[1]);
        void'(hist.pop_front());
      end
      hist.push_back({cs_n, sclk});
    end
  end

  function automatic bit exp_sdata();
    if (!m_oe || m_cnt >= 16) return 1'b0;
    return 1'(m_word >> (15 - m_cnt));
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, sdata_oe, m_oe, "sdata_oe");
      chk(cur_req, sdata, exp_sdata(), "sdata");
      chk(cur_req, powered, m_state == 0, "powered");
      chk(cur_req, data_valid, m_valid, "data_valid");
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame: n falls, optional probe of enable/valid 4 cycles after select falls
  task automatic frame(int n, string probe_req, logic exp_valid);
    cs_n = 1'b0;
    wait_n(4);
    if (probe_req != "") begin
      chk(probe_req, sdata_oe, 1'b1, "probe sdata_oe");
      chk(probe_req, data_valid, exp_valid, "probe data_valid");
    end
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; wait_n(2);
      sclk = 1'b1; wait_n(2);
    end
    cs_n = 1'b1;
    wait_n(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    cur_req = "R1";
    chk("R1", powered, 1'b1, "reset powered");
    chk("R1", sdata_oe, 1'b0, "reset sdata_oe");
    chk("R1", data_valid, 1'b0, "reset data_valid");
    chk("R1", sdata, 1'b0, "reset sdata");

    cur_req = "R2";
    frame(16, "R2", 1'b1);
    frame(16, "R2", 1'b1);
    chk("R2", powered, 1'b1, "after full frames");

    cur_req = "R3";
    frame(0, "", 1'b0);
    chk("R3", powered, 1'b1, "rise with 0 falls");
    frame(1, "", 1'b0);
    chk("R3", powered, 1'b1, "rise with 1 fall");

    cur_req = "R5";
    frame(10, "", 1'b0);
    chk("R5", powered, 1'b1, "rise with 10 falls");
    frame(13, "", 1'b0);
    chk("R5", powered, 1'b1, "rise with 13 falls");

    cur_req = "R9";
    frame(20, "", 1'b0);
    chk("R9", powered, 1'b1, "rise with 20 falls");
    chk("R9", sdata, 1'b0, "sdata after overlong frame");

    cur_req = "R4";
    frame(2, "", 1'b0);
    chk("R4", powered, 1'b0, "rise with 2 falls");
    chk("R4", sdata_oe, 1'b0, "enable after abort");

    cur_req = "R10";
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; wait_n(2);
      sclk = 1'b1; wait_n(2);
    end
    chk("R10", sdata_oe, 1'b0, "clock with select high");
    chk("R10", powered, 1'b0, "clock with select high");

    cur_req = "R7";
    frame(8, "R6", 1'b0);
    chk("R7", powered, 1'b0, "burst of 8 stays asleep");
    frame(9, "R6", 1'b0);
    chk("R7", powered, 1'b0, "9 falls stays asleep");

    cur_req = "R8";
    frame(12, "R6", 1'b0);
    chk("R8", powered, 1'b1, "wake by rise after 12");
    frame(16, "R8", 1'b1);

    cur_req = "R4";
    frame(9, "", 1'b0);
    chk("R4", powered, 1'b0, "rise with 9 falls");

    cur_req = "R8";
    frame(18, "R6", 1'b0);
    chk("R8", powered, 1'b1, "wake by full frame");
    frame(16, "R8", 1'b1);
    frame(16, "R2", 1'b1);

    cur_req = "R10";
    wait_n(6);
    chk("R10", sdata_oe, 1'b0, "idle enable");
    chk("R10", data_valid, 1'b0, "idle valid");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule